// File: doc/BRIEF.md
# Serial Converter Host Capture Controller

This block sits on the host side of a successive-approximation converter with a serial output, and it runs that converter. A conversion frame lasts fourteen converter clocks. The block derives the converter clock from the system clock and drives the converter's active-low start line. It samples the serial data line and assembles each 10-bit result, which it hands over with a one-cycle valid strobe. All of its logic runs in the system clock domain. The converter clock is a register that toggles on internal rise and fall enables.

There are three ways to start frames. In single-shot mode, one request produces one frame and the converter clock then stops. In synchronized mode, frames are chained, and the block inserts a programmable number of idle converter clocks between them. During those idle clocks the start line is high and the clock keeps running. In free-run mode, the start line stays low and frames follow each other every fourteen clocks.

The data line has one awkward timing window. Each bit is launched after a falling converter clock edge, and the least significant bit is valid only during the low phase that comes before the fourteenth rising edge. The block therefore samples every bit in the last system cycle before a rising edge, while the converter clock is still low.

Top module: `sar_serial_host`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the converter clock is low, the start line is high, busy is low and result_valid is low.
- R2: While running, the converter clock has a period of exactly 2*cfg_half system cycles and a high phase of exactly cfg_half cycles. A cfg_half of 0 acts as 1.
- R3: The start line only ever falls while the converter clock is low. For a single-shot frame, it falls exactly cfg_half system cycles before the first rising edge.
- R4: In single-shot mode (cfg_mode 0, or 3), a request produces exactly 14 rising converter edges and one frame. The start line returns high at the first rising edge. After the 14th falling edge the clock stays low and busy drops.
- R5: Bits are captured MSB first, on rising edges 5 through 14 of the frame. result holds the 10-bit word, and result_valid is high for exactly one system cycle, beginning at the edge where the 14th rise occurs.
- R6: The least significant bit is taken while the converter clock is low, before the 14th rising edge. A value that appears on the data line at or after that edge does not affect the result.
- R7: In synchronized mode (cfg_mode 1), the block inserts exactly cfg_gap rising converter edges with the start line high between consecutive frames. The clock keeps running through that gap. A cfg_gap of 0 chains frames with no idle edge.
- R8: In free-run mode (cfg_mode 2), the start line stays low and frames follow each other with no idle rising edge. Each frame has exactly 14 rising edges.
- R9: If the mode is changed to single-shot while chained frames are running, the start line goes high at the next rising edge. The frame in progress then completes and delivers its result, and no further frame begins.
- R10: A request that arrives while busy is high is ignored. It starts no additional frame.
- R11: busy is high from the cycle after a request is accepted until the clock stops. The converter clock never toggles while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_half | input | 8 | Converter clock half-period in system cycles (0 acts as 1) |
| cfg_mode | input | 2 | 0 or 3 single-shot, 1 synchronized, 2 free-run |
| cfg_gap | input | 8 | Idle converter clocks between frames in synchronized mode |
| req | input | 1 | Start request, accepted only while idle |
| busy | output | 1 | Frame or inter-frame gap in progress |
| conv_clk | output | 1 | Clock to the converter |
| conv_start_n | output | 1 | Active-low start line to the converter |
| conv_data | input | 1 | Serial data from the converter |
| result | output | 10 | Last assembled conversion word |
| result_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
A behavioural converter model supplies known words. The words include all ones, all zeros, a lone LSB, a lone MSB and alternating patterns, so that bit order and each end of the shift path can be seen. Right after the 14th rising edge, the model drives the inverse of the LSB onto the data line. A controller that samples late therefore returns a wrong low bit.

Single-shot runs at several half-periods, including 0, 1 and 3. They check clock shape, start-to-first-edge lead and the edge count. Synchronized runs with gaps of three and zero, and a free-run sequence, tell the three chaining policies apart by their idle-edge counts. A request issued mid-frame shows whether the block ignores it.

// File: rtl/sar_serial_host.sv
`timescale 1ns/1ps
module sar_serial_host #(
  parameter int DW         = 10,
  parameter int FRAME_CLKS = 14,
  parameter int HALF_W     = 8,
  parameter int GAP_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] cfg_half,
  input  logic [1:0]        cfg_mode,
  input  logic [GAP_W-1:0]  cfg_gap,
  input  logic              req,
  output logic              busy,
  output logic              conv_clk,
  output logic              conv_start_n,
  input  logic              conv_data,
  output logic [DW-1:0]     result,
  output logic              result_valid
);
  localparam int CNT_W = $clog2(FRAME_CLKS + 1);
  localparam logic [CNT_W-1:0] FIRST_CAP = CNT_W'(FRAME_CLKS - DW);
  localparam logic [CNT_W-1:0] LAST_CAP  = CNT_W'(FRAME_CLKS - 1);
  localparam logic [CNT_W-1:0] END_CNT   = CNT_W'(FRAME_CLKS);
  localparam logic [1:0] M_SYNC = 2'd1;
  localparam logic [1:0] M_FREE = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_FRAME, S_GAP} state_t;

  state_t            st;
  logic [HALF_W-1:0] hcnt;
  logic [CNT_W-1:0]  ncnt;
  logic [GAP_W-1:0]  gcnt;
  logic [DW-2:0]     shreg;
  logic [DW-1:0]     res_q;
  logic              sclk_q, start_q, vld_q;

  wire [HALF_W-1:0] half_eff = (cfg_half == '0) ? HALF_W'(1) : cfg_half;
  wire running   = (st != S_IDLE);
  wire tick      = running && (hcnt == '0);
  wire rise_en   = tick && !sclk_q;
  wire fall_en   = tick && sclk_q;
  wire in_frame  = (st == S_FRAME);
  wire cap       = rise_en && in_frame && (ncnt >= FIRST_CAP) && (ncnt <= LAST_CAP);
  wire last_cap  = rise_en && in_frame && (ncnt == LAST_CAP);
  wire frame_end = fall_en && in_frame && (ncnt == END_CNT);
  wire chain_now = (cfg_mode == M_FREE) || ((cfg_mode == M_SYNC) && (cfg_gap == '0));
  wire keep_on   = (cfg_mode == M_FREE) || (cfg_mode == M_SYNC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      hcnt    <= '0;
      ncnt    <= '0;
      gcnt    <= '0;
      shreg   <= '0;
      res_q   <= '0;
      sclk_q  <= 1'b0;
      start_q <= 1'b1;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= last_cap;
      if (cap)      shreg <= {shreg[DW-3:0], conv_data};
      if (last_cap) res_q <= {shreg, conv_data};
      if (running)  hcnt  <= tick ? half_eff - 1'b1 : hcnt - 1'b1;
      if (tick)     sclk_q <= !sclk_q;

      case (st)
        S_IDLE: if (req) begin
          st      <= S_FRAME;
          start_q <= 1'b0;
          ncnt    <= '0;
          hcnt    <= half_eff - 1'b1;
        end
        S_FRAME: begin
          if (rise_en) begin
            ncnt    <= ncnt + 1'b1;
            start_q <= (cfg_mode != M_FREE);
          end
          if (frame_end) begin
            ncnt <= '0;
            if (chain_now) start_q <= 1'b0;
            else begin
              start_q <= 1'b1;
              if (cfg_mode == M_SYNC) begin
                st   <= S_GAP;
                gcnt <= cfg_gap;
              end else st <= S_IDLE;
            end
          end
        end
        S_GAP: begin
          if (rise_en) gcnt <= gcnt - 1'b1;
          if (fall_en && gcnt == '0) begin
            if (keep_on) begin
              start_q <= 1'b0;
              st      <= S_FRAME;
            end else st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy         = running;
  assign conv_clk     = sclk_q;
  assign conv_start_n = start_q;
  assign result       = res_q;
  assign result_valid = vld_q;
endmodule

// File: rtl/sar_serial_host_chk.sv
`timescale 1ns/1ps
module sar_serial_host_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_mode,
  input logic       busy,
  input logic       conv_clk,
  input logic       conv_start_n,
  input logic       result_valid
);
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (conv_start_n && !conv_clk && !busy && !result_valid));

  a_r11_clock_stopped_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !conv_clk);

  a_r3_start_falls_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_start_n) |-> !conv_clk);

  a_r5_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  a_r4_line_released_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> conv_start_n);

  a_r9_start_high_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(conv_clk) && $past(cfg_mode) != 2'd2) |-> conv_start_n);
endmodule

bind sar_serial_host sar_serial_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .busy(busy),
  .conv_clk(conv_clk), .conv_start_n(conv_start_n), .result_valid(result_valid)
);

// File: tb/sar_serial_host_bench.sv
`timescale 1ns/1ps
module sar_serial_host_bench;
  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, sdata = 1'b0;
  logic [7:0] cfg_half = 8'd2, cfg_gap = 8'd0;
  logic [1:0] cfg_mode = 2'd0;
  logic busy, sclk, start_n, rvalid;
  logic [9:0] result;

  sar_serial_host u_sar_serial_host (
    .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .cfg_mode(cfg_mode),
    .cfg_gap(cfg_gap), .req(req), .busy(busy), .conv_clk(sclk),
    .conv_start_n(start_n), .conv_data(sdata), .result(result),
    .result_valid(rvalid));

  always #4 clk = ~clk;

  int errors = 0, checks = 0, sb_errors = 0, sb_checks = 0;
  logic [9:0] conv_q[$], exp_q[$];

  // converter model
  int mcnt = 0, frames = 0, idle_rises = 0, rises = 0;
  logic [9:0] mval = '0;
  logic sn_s = 1'b1;
  time t_prev = 0, period = 0, hi_len = 0, t_sn_fall = 0, lead = 0;

  always @(sclk) begin
    if (sclk) begin
      rises++;
      period = $time - t_prev;
      t_prev = $time;
      if (mcnt == 0) begin
        if (!sn_s) begin
          mcnt = 1;
          frames++;
          lead = $time - t_sn_fall;
          mval = (conv_q.size() > 0) ? conv_q.pop_front() : 10'd0;
          #1 sdata = 1'b0;
        end else idle_rises++;
      end else begin
        mcnt++;
        if (mcnt == 14) begin
          #1 sdata = ~mval[0];  // LSB window has closed
        end
      end
    end else begin
      hi_len = $time - t_prev;
      if (mcnt >= 4 && mcnt <= 13) begin
        #1 sdata = mval[13 - mcnt];
      end else if (mcnt == 14) begin
        mcnt = 0;
        #1 sdata = 1'b0;  // released or held low, seen as 0 either way
      end
    end
  end

  always @(negedge start_n) t_sn_fall = $time;

  // monitors
  int sn_bad = 0, free_hi = 0;
  bit track_free = 0;
  always @(negedge clk) begin
    if (rst_n && sn_s && !start_n && sclk) sn_bad++;
    if (track_free && start_n) free_hi++;
    sn_s = start_n;
    if (rst_n && rvalid) begin
      sb_checks++;
      if (exp_q.size() == 0) begin
        sb_errors++;
        $display("FAIL R5 unexpected result: actual=%0h expected=none", result);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        if (result !== e) begin
          sb_errors++;
          $display("FAIL R5/R6 result word: actual=%0h expected=%0h", result, e);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [9:0] v);
    conv_q.push_back(v);
    exp_q.push_back(v);
  endtask

  task automatic pulse_req();
    @(negedge clk) req = 1'b1;
    @(negedge clk) req = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_frames(input int n);
    while (frames < n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors + sb_errors, checks + sb_checks);
  endtask

  task automatic run_single(input logic [7:0] h, input logic [9:0] v);
    int f0, r0;
    longint he;
    he = (h == 0) ? 1 : h;
    cfg_half = h; cfg_mode = 2'd0;
    push(v);
    f0 = frames; r0 = rises;
    pulse_req();
    wait_idle();
    chk(frames - f0 == 1, "R4 frames per request", frames - f0, 1);
    chk(rises - r0 == 14, "R4 rising edges per frame", rises - r0, 14);
    chk(period == 2 * he * 8, "R2 clock period ns", period, 2 * he * 8);
    chk(hi_len == he * 8, "R2 high phase ns", hi_len, he * 8);
    chk(lead == he * 8, "R3 start lead ns", lead, he * 8);
    chk(start_n && !sclk && !busy, "R4 stopped and released", {start_n, sclk, busy}, 3'b100);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int f0, i0, r0;
    repeat (3) @(negedge clk);
    chk(start_n && !sclk && !busy && !rvalid, "R1 reset state",
        {start_n, sclk, busy, rvalid}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(start_n && !sclk && !busy && !rvalid, "R1 after release",
        {start_n, sclk, busy, rvalid}, 4'b1000);

    // R2 R4 R5 R6 across patterns and divider settings
    run_single(8'd2, 10'h2A5);
    run_single(8'd1, 10'h3FF);
    run_single(8'd0, 10'h001);
    run_single(8'd3, 10'h000);
    run_single(8'd2, 10'h200);
    run_single(8'd1, 10'h155);

    // R10 request while busy
    cfg_half = 8'd2; cfg_mode = 2'd0;
    push(10'h133);
    f0 = frames;
    pulse_req();
    repeat (20) @(negedge clk);
    pulse_req();
    wait_idle();
    repeat (60) @(negedge clk);
    chk(frames - f0 == 1, "R10 request while busy ignored", frames - f0, 1);
    chk(!busy, "R10 idle afterwards", busy, 0);

    // R7 synchronized with gap 3
    cfg_half = 8'd1; cfg_mode = 2'd1; cfg_gap = 8'd3;
    push(10'h0F0); push(10'h30C); push(10'h081);
    f0 = frames; i0 = idle_rises; r0 = rises;
    pulse_req();
    wait_frames(f0 + 3);
    cfg_mode = 2'd0;
    wait_idle();
    chk(frames - f0 == 3, "R7 sync frames", frames - f0, 3);
    chk(idle_rises - i0 == 6, "R7 gap edges", idle_rises - i0, 6);
    chk(rises - r0 == 48, "R7 clock runs through gap", rises - r0, 48);

    // R7 synchronized with gap 0
    cfg_mode = 2'd1; cfg_gap = 8'd0;
    push(10'h1E1); push(10'h2D2);
    f0 = frames; i0 = idle_rises;
    pulse_req();
    wait_frames(f0 + 2);
    cfg_mode = 2'd0;
    wait_idle();
    chk(frames - f0 == 2, "R7 zero gap frames", frames - f0, 2);
    chk(idle_rises - i0 == 0, "R7 zero gap edges", idle_rises - i0, 0);

    // R8 free run, R9 leaving it
    cfg_half = 8'd2; cfg_mode = 2'd2;
    push(10'h3C3); push(10'h00F); push(10'h2AA); push(10'h111);
    f0 = frames; i0 = idle_rises; r0 = rises;
    pulse_req();
    track_free = 1;
    wait_frames(f0 + 4);
    track_free = 0;
    cfg_mode = 2'd0;
    wait_idle();
    repeat (40) @(negedge clk);
    chk(free_hi == 0, "R8 start held low", free_hi, 0);
    chk(idle_rises - i0 == 0, "R8 no idle edges", idle_rises - i0, 0);
    chk(rises - r0 == 56, "R8 fourteen edges per frame", rises - r0, 56);
    chk(frames - f0 == 4, "R9 exactly the running frame completes", frames - f0, 4);
    chk(start_n && !busy, "R9 stopped with line released", {start_n, busy}, 2'b10);
    chk(period == 32, "R2 period in free run ns", period, 32);

    chk(sn_bad == 0, "R3 start never falls with clock high", sn_bad, 0);
    chk(exp_q.size() == 0, "R5 every expected result delivered", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule